// File: doc/BRIEF.md
# Per-Processor Interrupt Enable Aggregator

This block collects a wide vector of level-sensitive interrupt sources and gives each processor in a cluster its own set of enable masks over those sources. Every processor gets one interrupt output. That output is raised while at least one source is active and also enabled in that processor's masks. Software reaches every mask and every raw status word through a small register port. The port has a word address, write data, a write strobe, a read strobe and registered read data.

The sources are grouped into 32-bit words. Each processor owns a contiguous bank of registers. The bank holds its enable words first and then one status word per source word. The status words show the same synchronized source state in every bank; only the enable masks differ between processors. The word order is reversed relative to the source numbering, so the first word of each group holds the highest-numbered sources. Software steers a source to a processor by enabling it in that processor's bank only. The block applies no priority, no latching and no vectoring.

Top module: `intc_en_aggregator`

## Requirements
- R1: During and directly after a synchronous active-low reset, every enable word reads as 0, every interrupt output is 0 and the read data is 0.
- R2: `addr` is a word address (byte offset divided by 4). Processor k's bank starts at word k×2×NUM_WORDS. Enable word w sits at bank start + w, and status word w sits at bank start + NUM_WORDS + w.
- R3: Bit b of status word w reflects source (NUM_WORDS−1−w)×32 + b. Word 0 therefore carries the highest 32 sources, and word NUM_WORDS−1 carries sources 0–31.
- R4: Sources pass through a two-flop synchronizer before status and interrupt logic. The status words read identically from every processor's bank.
- R5: A write to an enable word replaces all 32 bits of that one word for that one processor. No other enable word of any processor changes.
- R6: Interrupt output k is registered. It equals the OR over all words of (status AND processor k's enable), taken one cycle after the status and enable values. A source change therefore reaches the output on the third rising edge.
- R7: When all enable words of a processor are zero, its interrupt output is 0 one cycle later, whatever the sources are.
- R8: Writes to status word addresses change no register.
- R9: A read from an address at or beyond NUM_CPUS×2×NUM_WORDS returns 0. A write there changes nothing.
- R10: `rd_data` is updated on a rising edge where `rd_en` is 1, with the addressed word. It holds its value on edges where `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src | input | 32×NUM_WORDS | Level-sensitive interrupt sources, asynchronous |
| addr | input | ADDR_W | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq | output | NUM_CPUS | One interrupt output per processor |

## Verification
The assertions check on every cycle that each output follows the registered AND-OR of status and enables, and that a fully cleared bank silences its output. They also check that a write aimed at one processor, at a status word or outside the block leaves the other masks untouched, and that reset clears the masks. Only the bench's scenarios can show the address map and the reversed word order of the sources. The same holds for the synchronizer delay seen at the output, the zero read-back outside the block, and read data holding between strobes. To cover these, the bench sweeps every single source through every bank with complementary masks.

// File: rtl/intc_pkg.sv
// Shared definitions for the interrupt enable aggregator.
// Assumes a fixed 32-bit register word.
package intc_pkg;
    localparam int WORD_BITS = 32;
    typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/intc_src_sync.sv
// Two-flop synchronizer for the raw source vector.
// Assumes sources are levels that stay stable for several cycles.
module intc_src_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages bring the sources into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/intc_addr_decode.sv
// Splits a word address into processor index, word index and register kind.
// Assumes ADDR_W is wide enough to cover every bank.
module intc_addr_decode #(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_status,
    output logic [ADDR_W-1:0] cpu_idx,
    output logic [ADDR_W-1:0] word_idx
);
    localparam int BANK_WORDS = 2 * NUM_WORDS;

    logic [ADDR_W-1:0] offset;

    // Bank number and offset inside the bank.
    always_comb begin
        cpu_idx = addr / ADDR_W'(BANK_WORDS);
        offset  = addr % ADDR_W'(BANK_WORDS);
    end

    // The upper half of a bank holds status words, the lower half enables.
    always_comb begin
        is_status = (offset >= ADDR_W'(NUM_WORDS));
        word_idx  = is_status ? (offset - ADDR_W'(NUM_WORDS)) : offset;
        hit       = (cpu_idx < ADDR_W'(NUM_CPUS));
    end
endmodule

// File: rtl/intc_cpu_bank.sv
// Enable masks and the interrupt output of one processor.
// Assumes wr_stb is already qualified for this bank and for an enable word.
module intc_cpu_bank
    import intc_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [IDX_W-1:0]         word_sel,
    input  word_t                    wr_data,
    input  word_t [NUM_WORDS-1:0]    status,
    output word_t [NUM_WORDS-1:0]    enables,
    output logic                     irq
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_t en_q;

        // Whole-word replacement of one enable mask.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q <= '0;
            else if (wr_stb && (word_sel == IDX_W'(w)))
                en_q <= wr_data;
        end

        assign enables[w] = en_q;
    end

    // Registered OR of every pending and enabled source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(status & enables);
    end
endmodule

// File: rtl/intc_read_mux.sv
// Selects and registers the addressed word for a read.
// Assumes status words are shared by all banks.
module intc_read_mux
    import intc_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_en,
    input  logic                                  hit,
    input  logic                                  is_status,
    input  logic [IDX_W-1:0]                      cpu_idx,
    input  logic [IDX_W-1:0]                      word_idx,
    input  word_t [NUM_CPUS-1:0][NUM_WORDS-1:0]   en_all,
    input  word_t [NUM_WORDS-1:0]                 status,
    output word_t                                 rd_data
);
    word_t sel;

    // Pick the word; anything outside the block reads as zero.
    always_comb begin
        sel = '0;
        if (hit) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (cpu_idx == IDX_W'(c) && word_idx == IDX_W'(w))
                        sel = is_status ? status[w] : en_all[c][w];
                end
            end
        end
    end

    // Capture on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel;
    end
endmodule

// File: rtl/intc_en_aggregator.sv
// Top level: per-processor enable banks over a shared source vector.
// Assumes one register access per cycle and asynchronous level sources.
module intc_en_aggregator
    import intc_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_BITS*NUM_WORDS-1:0] src,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr_en,
    input  logic [WORD_BITS-1:0]          wr_data,
    input  logic                          rd_en,
    output logic [WORD_BITS-1:0]          rd_data,
    output logic [NUM_CPUS-1:0]           irq
);
    localparam int SRC_W = WORD_BITS * NUM_WORDS;

    logic [SRC_W-1:0]                     src_q;
    word_t [NUM_WORDS-1:0]                status_w;
    word_t [NUM_CPUS-1:0][NUM_WORDS-1:0]  en_all;
    logic                                 dec_hit;
    logic                                 dec_status;
    logic [ADDR_W-1:0]                    dec_cpu;
    logic [ADDR_W-1:0]                    dec_word;

    intc_src_sync #(.W(SRC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (src),
        .d_sync  (src_q)
    );

    // Word 0 carries the highest sources; the last word carries 0..31.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_status
        assign status_w[w] = src_q[(NUM_WORDS-1-w)*WORD_BITS +: WORD_BITS];
    end

    intc_addr_decode #(
        .NUM_CPUS  (NUM_CPUS),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr      (addr),
        .hit       (dec_hit),
        .is_status (dec_status),
        .cpu_idx   (dec_cpu),
        .word_idx  (dec_word)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic bank_wr;

        // Only enable-word writes inside this bank reach it.
        assign bank_wr = wr_en && dec_hit && !dec_status && (dec_cpu == ADDR_W'(c));

        intc_cpu_bank #(
            .NUM_WORDS (NUM_WORDS),
            .IDX_W     (ADDR_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (bank_wr),
            .word_sel (dec_word),
            .wr_data  (wr_data),
            .status   (status_w),
            .enables  (en_all[c]),
            .irq      (irq[c])
        );
    end

    intc_read_mux #(
        .NUM_CPUS  (NUM_CPUS),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (ADDR_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .hit       (dec_hit),
        .is_status (dec_status),
        .cpu_idx   (dec_cpu),
        .word_idx  (dec_word),
        .en_all    (en_all),
        .status    (status_w),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/intc_en_checker.sv
// Cycle-level properties of the aggregator, bound to its top module.
// Assumes it observes the decoder outputs, enable masks and status words.
module intc_en_checker
    import intc_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 wr_en,
    input logic                                 dec_hit,
    input logic                                 dec_status,
    input logic [IDX_W-1:0]                     dec_cpu,
    input word_t [NUM_CPUS-1:0][NUM_WORDS-1:0]  en_all,
    input word_t [NUM_WORDS-1:0]                status_w,
    input logic [NUM_CPUS-1:0]                  irq
);
    // R1: reset clears masks and outputs
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (en_all == '0) && (irq == '0));

    // R8 and R9: status or out-of-range writes leave every mask alone
    p_inert_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!dec_hit || dec_status)) |=> $stable(en_all));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        // R6: output follows the previous cycle's status and mask
        p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq[c] == |($past(status_w) & $past(en_all[c]))));

        // R7: an empty bank silences its output
        p_cleared_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[c] == '0) |=> !irq[c]);

        // R5: a write aimed at another bank leaves this one unchanged
        p_other_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && dec_hit && !dec_status && (dec_cpu != IDX_W'(c)))
            |=> $stable(en_all[c]));
    end
endmodule

bind intc_en_aggregator intc_en_checker #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .dec_hit    (dec_hit),
    .dec_status (dec_status),
    .dec_cpu    (dec_cpu),
    .en_all     (en_all),
    .status_w   (status_w),
    .irq        (irq)
);

// File: tb/tb_intc_en_aggregator.sv
module tb_intc_en_aggregator;
    localparam int NC = 2;
    localparam int NW = 2;
    localparam int AW = 6;
    localparam int SPAN = NC * 2 * NW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [32*NW-1:0]  src = '0;
    logic [AW-1:0]     addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [31:0]       rd_data;
    logic [NC-1:0]     irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intc_en_aggregator #(.NUM_CPUS(NC), .NUM_WORDS(NW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src(src), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [AW-1:0] en_addr(int c, int w);
        return AW'(c * 2 * NW + w);
    endfunction

    function automatic logic [AW-1:0] st_addr(int c, int w);
        return AW'(c * 2 * NW + NW + w);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
                wr(en_addr(c, w), 32'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] held;
        // R1: reset with active sources
        src = '1;
        repeat (4) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 32'h0);
        chk("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                rd(en_addr(c, w), d);
                chk("R1 enable reset value", d, 32'h0);
            end
        src = '0;
        settle();

        // R2 R5: distinct patterns everywhere, then read all back
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
                wr(en_addr(c, w), 32'h5A00_0000 ^ 32'(c << 12) ^ 32'(w * 32'h0101_0011));
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                rd(en_addr(c, w), d);
                chk("R2 R5 enable read-back", d, 32'h5A00_0000 ^ 32'(c << 12) ^ 32'(w * 32'h0101_0011));
            end
        // R5: overwrite one word only
        wr(en_addr(1, 0), 32'hFFFF_0000);
        rd(en_addr(1, 0), d);
        chk("R5 whole-word replace", d, 32'hFFFF_0000);
        rd(en_addr(0, 0), d);
        chk("R5 other bank untouched", d, 32'h5A00_0000);
        clear_all();

        // R3 R4 R6: sweep every source through both banks
        for (int s = 0; s < 32 * NW; s++) begin
            int ws;
            logic [31:0] bit_s;
            ws = NW - 1 - s / 32;
            bit_s = 32'h1 << (s % 32);
            src = '0;
            src[s] = 1'b1;
            settle();
            for (int c = 0; c < NC; c++)
                for (int w = 0; w < NW; w++) begin
                    rd(st_addr(c, w), d);
                    chk("R3 R4 status word", d, (w == ws) ? bit_s : 32'h0);
                end
            wr(en_addr(0, ws), bit_s);
            wr(en_addr(1, ws), ~bit_s);
            settle();
            chk("R6 irq routed to cpu0", 32'(irq), 32'h1);
            wr(en_addr(0, ws), ~bit_s);
            wr(en_addr(1, ws), bit_s);
            settle();
            chk("R6 irq routed to cpu1", 32'(irq), 32'h2);
            wr(en_addr(0, ws), 32'h0);
            wr(en_addr(1, ws), 32'h0);
        end

        // R6: one-cycle latency after an enable write
        src = '0; src[0] = 1'b1;
        settle();
        wr(en_addr(0, NW - 1), 32'h1);
        chk("R6 irq not yet raised", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R6 irq raised next cycle", 32'(irq), 32'h1);
        // R4 R6: source reaches the output on the third edge
        src = '0;
        settle();
        src[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 synchronizer delay", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R4 R6 output after third edge", 32'(irq), 32'h1);

        // R7: clearing a bank silences it with all sources active
        src = '1;
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
                wr(en_addr(c, w), 32'hFFFF_FFFF);
        settle();
        chk("R7 both raised", 32'(irq), 32'h3);
        for (int w = 0; w < NW; w++) wr(en_addr(0, w), 32'h0);
        settle();
        chk("R7 cpu0 cleared", 32'(irq), 32'h2);
        for (int w = 0; w < NW; w++) wr(en_addr(1, w), 32'h0);
        settle();
        chk("R7 cpu1 cleared", 32'(irq), 32'h0);

        // R8: status writes change no mask and no status
        src = {32'h1234_5678, 32'h9ABC_DEF0};
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
                wr(st_addr(c, w), 32'hFFFF_FFFF);
        settle();
        chk("R8 irq stays low", 32'(irq), 32'h0);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                rd(en_addr(c, w), d);
                chk("R8 enable unchanged", d, 32'h0);
                rd(st_addr(c, w), d);
                chk("R8 status unchanged", d, (w == 0) ? 32'h1234_5678 : 32'h9ABC_DEF0);
            end

        // R9: outside the block
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++)
                wr(en_addr(c, w), 32'hC0DE_0000 | 32'(c * 16 + w));
        for (int a = SPAN; a < (1 << AW); a++) begin
            wr(AW'(a), 32'hDEAD_BEEF);
            rd(AW'(a), d);
            chk("R9 out-of-range read", d, 32'h0);
        end
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                rd(en_addr(c, w), d);
                chk("R9 out-of-range write inert", d, 32'hC0DE_0000 | 32'(c * 16 + w));
            end

        // R10: read data holds without a strobe
        rd(en_addr(1, 1), held);
        wr(en_addr(1, 1), 32'h0F0F_0F0F);
        addr = en_addr(0, 0);
        repeat (3) @(negedge clk);
        chk("R10 rd_data held", rd_data, held);
        rd(en_addr(1, 1), d);
        chk("R10 rd_data updated on strobe", d, 32'h0F0F_0F0F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule